// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 interrupt request lines and presents them to a processor as one interrupt output. Each line is captured into a status word. A line can be configured as edge-sensitive, which latches on a rising edge, or as level-sensitive, which latches for as long as the input is high. The status word is gated by a per-line enable word. The lowest-numbered line that is both pending and enabled is reported as a vector index. The processor output is raised only when two master control bits are both set.

Software reaches the block through eight 32-bit word registers. It gives a 3-bit word index, a write strobe and write data. Writes take effect at the clock edge that samples them. Read data appears one cycle after the index is presented. The enable word can be loaded whole. It can also be changed one bit group at a time through a set-only register and a clear-only register, so a driver never needs a read-modify-write sequence. Latched requests are cleared by writing ones to an acknowledge register.

Top module: `intr_hub`

## Requirements
- R1: After reset, the status, enable and master words are all zero, `cpu_irq` is low and `bus_rdata` is zero.
- R2: Word index 2 (byte offset 0x08) loads the enable word. A write to index 4 (0x10) sets the enable bits that are 1 in the data and leaves the others unchanged. A write to index 5 (0x14) clears only the enable bits that are 1 in the data.
- R3: A write to index 3 (0x0C) clears every latched status bit whose data bit is 1. Writing all ones clears every latched request, except level-sensitive lines whose input is still high.
- R4: Index 7 (0x1C) holds bit 0, the processor-output enable, and bit 1, the hardware-request enable. Both read back exactly as written. Its other bits read as zero.
- R5: Reading index 6 (0x18) returns the lowest index whose pending bit is set. When no line is pending, it returns 0xFFFFFFFF.
- R6: An edge-sensitive line sets its status bit at the clock edge that first samples the input high after it was sampled low. The bit stays set until it is acknowledged, whatever the input does.
- R7: A level-sensitive line sets its status bit at every edge where its input is sampled high. This includes the edge that carries an acknowledge for that line, so the bit stays set after that acknowledge.
- R8: Reading index 1 (0x04) returns the status word ANDed with the enable word.
- R9: `cpu_irq` is high exactly when both master bits are 1 and at least one pending bit is set. It reflects register state, with no further delay.
- R10: A write to index 0 (0x00) ORs the data into the status word while master bit 1 is 0. The write has no effect while that bit is 1.
- R11: `bus_rdata` shows, one cycle after a word index is sampled, the value of that register before that edge. Bits at or above NUM_LINES read as zero. The write-only indices 3, 4 and 5 read as zero.
- R12: EDGE_MASK bit i selects edge detection for line i when it is 1 and level detection when it is 0. Bits at or above NUM_LINES have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Interrupt request lines |
| bus_addr | input | 3 | Word index of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, one cycle latency |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that the request inputs are synchronous to `clk` and are sampled the same way as any other input. They also assume that only one register access is made per cycle. The stimulus changes `irq_in` only at falling edges, and drives exactly one index with its strobe and data in each cycle. Random writes cover every word index, including the status register with the hardware-request bit both set and clear. Request lines toggle at random, so edge and level lines both see rising edges, held highs and acknowledges that coincide with new requests.

// File: rtl/intr_hub_pkg.sv
package intr_hub_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned SEL_W  = 3;

    // Word index of each register; the index order is fixed by the register map.
    typedef enum logic [SEL_W-1:0] {
        RSEL_STATUS = 3'd0,
        RSEL_PEND   = 3'd1,
        RSEL_ENABLE = 3'd2,
        RSEL_ACK    = 3'd3,
        RSEL_EN_SET = 3'd4,
        RSEL_EN_CLR = 3'd5,
        RSEL_VECTOR = 3'd6,
        RSEL_MASTER = 3'd7
    } reg_sel_e;

    // Master word: bit 1 = hardware-request enable, bit 0 = processor-output enable.
    typedef struct packed {
        logic hw_en;
        logic cpu_en;
    } master_t;

    typedef struct packed {
        logic status;
        logic ack;
        logic en_load;
        logic en_set;
        logic en_clr;
        logic master;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic we, input reg_sel_e sel);
        wr_strobe_t s;
        s         = '0;
        s.status  = we && (sel == RSEL_STATUS);
        s.ack     = we && (sel == RSEL_ACK);
        s.en_load = we && (sel == RSEL_ENABLE);
        s.en_set  = we && (sel == RSEL_EN_SET);
        s.en_clr  = we && (sel == RSEL_EN_CLR);
        s.master  = we && (sel == RSEL_MASTER);
        return s;
    endfunction

endpackage

// File: rtl/intr_hub_capture.sv
module intr_hub_capture #(
    parameter int unsigned NUM_LINES = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] ack_mask,
    input  logic [NUM_LINES-1:0] sw_mask,
    output logic [NUM_LINES-1:0] status_q
);

    logic [NUM_LINES-1:0] irq_prev_q;
    logic [NUM_LINES-1:0] capture;

    // Each line picks its detector; only mask bits below NUM_LINES are looked at.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        if (EDGE_MASK[g]) begin : g_edge
            assign capture[g] = irq_in[g] & ~irq_prev_q[g];
        end else begin : g_level
            assign capture[g] = irq_in[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_prev_q <= '0;
            status_q   <= '0;
        end else begin
            irq_prev_q <= irq_in;
            // A new capture in the same cycle as an acknowledge wins.
            status_q   <= (status_q & ~ack_mask) | capture | sw_mask;
        end
    end

endmodule

// File: rtl/intr_hub_ctrl.sv
module intr_hub_ctrl
    import intr_hub_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  wr_strobe_t           strb,
    input  logic [NUM_LINES-1:0] wmask,
    input  logic [1:0]           wmaster,
    output logic [NUM_LINES-1:0] enable_q,
    output master_t              master_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            master_q <= '0;
        end else begin
            if (strb.en_load) begin
                enable_q <= wmask;
            end else if (strb.en_set) begin
                enable_q <= enable_q | wmask;
            end else if (strb.en_clr) begin
                enable_q <= enable_q & ~wmask;
            end
            if (strb.master) begin
                master_q <= master_t'(wmaster);
            end
        end
    end

endmodule

// File: rtl/intr_hub_prio.sv
module intr_hub_prio #(
    parameter int unsigned NUM_LINES = 32,
    localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0] pend,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx
);

    // Scan from the top so the lowest set index is the one left standing.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/intr_hub.sv
module intr_hub
    import intr_hub_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0,
    localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [SEL_W-1:0]     bus_addr,
    input  logic                 bus_we,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic                 cpu_irq
);

    reg_sel_e             wr_sel;
    wr_strobe_t           strb;
    logic [NUM_LINES-1:0] line_wdata;
    logic [NUM_LINES-1:0] ack_mask;
    logic [NUM_LINES-1:0] sw_mask;
    logic [NUM_LINES-1:0] status_q;
    logic [NUM_LINES-1:0] enable_q;
    master_t              master_q;
    logic [NUM_LINES-1:0] pend;
    logic                 vec_hit;
    logic [IDX_W-1:0]     vec_idx;
    logic [WORD_W-1:0]    rd_next;

    assign wr_sel     = reg_sel_e'(bus_addr);
    assign strb       = decode_write(bus_we, wr_sel);
    assign line_wdata = bus_wdata[NUM_LINES-1:0];
    assign ack_mask   = strb.ack ? line_wdata : '0;
    assign sw_mask    = (strb.status && !master_q.hw_en) ? line_wdata : '0;

    intr_hub_capture #(
        .NUM_LINES (NUM_LINES),
        .EDGE_MASK (EDGE_MASK)
    ) u_capture (
        .clk      (clk),
        .rst      (rst),
        .irq_in   (irq_in),
        .ack_mask (ack_mask),
        .sw_mask  (sw_mask),
        .status_q (status_q)
    );

    intr_hub_ctrl #(
        .NUM_LINES (NUM_LINES)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .strb     (strb),
        .wmask    (line_wdata),
        .wmaster  (bus_wdata[1:0]),
        .enable_q (enable_q),
        .master_q (master_q)
    );

    assign pend = status_q & enable_q;

    intr_hub_prio #(
        .NUM_LINES (NUM_LINES)
    ) u_prio (
        .pend (pend),
        .hit  (vec_hit),
        .idx  (vec_idx)
    );

    assign cpu_irq = master_q.cpu_en & master_q.hw_en & (|pend);

    always_comb begin
        rd_next = '0;
        unique case (wr_sel)
            RSEL_STATUS: rd_next = WORD_W'(status_q);
            RSEL_PEND:   rd_next = WORD_W'(pend);
            RSEL_ENABLE: rd_next = WORD_W'(enable_q);
            RSEL_VECTOR: rd_next = vec_hit ? WORD_W'(vec_idx) : '1;
            RSEL_MASTER: rd_next = WORD_W'(master_q);
            default:     rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_next;
        end
    end

endmodule

// File: rtl/intr_hub_chk.sv
module intr_hub_chk #(
    parameter int unsigned NUM_LINES = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0,
    localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] irq_in,
    input logic [2:0]           bus_addr,
    input logic                 bus_we,
    input logic [31:0]          bus_wdata,
    input logic [NUM_LINES-1:0] status_q,
    input logic [NUM_LINES-1:0] enable_q,
    input logic [1:0]           master_q,
    input logic [NUM_LINES-1:0] pend,
    input logic                 vec_hit,
    input logic [IDX_W-1:0]     vec_idx
);

    localparam logic [NUM_LINES-1:0] LEVEL_LINES = ~EDGE_MASK[NUM_LINES-1:0];

    logic [NUM_LINES-1:0] below_idx;
    assign below_idx = (NUM_LINES'(1) << vec_idx) - NUM_LINES'(1);

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd4) |=>
        ((enable_q & $past(bus_wdata[NUM_LINES-1:0])) == $past(bus_wdata[NUM_LINES-1:0])));

    // R2
    en_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd5) |=>
        ((enable_q & $past(bus_wdata[NUM_LINES-1:0])) == '0));

    // R4
    master_rb_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd7) |=> (master_q == $past(bus_wdata[1:0])));

    // R5
    vec_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        vec_hit |-> (pend[vec_idx] && ((pend & below_idx) == '0)));

    // R5
    vec_none_chk: assert property (@(posedge clk) disable iff (rst)
        !vec_hit |-> (pend == '0));

    // R6
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == 3'd3) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R7
    level_latch_chk: assert property (@(posedge clk) disable iff (rst)
        ((irq_in & LEVEL_LINES) != '0) |=>
        ((status_q & $past(irq_in & LEVEL_LINES)) == $past(irq_in & LEVEL_LINES)));

endmodule

bind intr_hub intr_hub_chk #(
    .NUM_LINES (NUM_LINES),
    .EDGE_MASK (EDGE_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .master_q  (master_q),
    .pend      (pend),
    .vec_hit   (vec_hit),
    .vec_idx   (vec_idx)
);

// File: tb/intr_hub_tb.sv
module intr_hub_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 20;
    localparam logic [31:0] EDGE = 32'hFFF0_0F0F;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] irq_in = '0;
    logic [2:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [N-1:0] m_st, m_en, m_prev;
    logic [1:0]   m_mer;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_hub #(.NUM_LINES(N), .EDGE_MASK(EDGE)) u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] a);
        case (a)
            3'd0: return "R10";
            3'd1: return "R8";
            3'd2: return "R2";
            3'd6: return "R5";
            3'd7: return "R4";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [31:0] m_vec();
        logic [31:0] v = 32'hFFFF_FFFF;
        for (int i = N - 1; i >= 0; i--) if (m_st[i] & m_en[i]) v = i;
        return v;
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return 32'(m_st);
            3'd1: return 32'(m_st & m_en);
            3'd2: return 32'(m_en);
            3'd6: return m_vec();
            3'd7: return 32'(m_mer);
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_update(input logic [2:0] a, input logic we, input logic [31:0] d,
                            input logic [N-1:0] irq);
        logic [N-1:0] cap, ackm, swm;
        for (int i = 0; i < N; i++) cap[i] = EDGE[i] ? (irq[i] & ~m_prev[i]) : irq[i];
        ackm = (we && a == 3'd3) ? d[N-1:0] : '0;
        swm  = (we && a == 3'd0 && !m_mer[1]) ? d[N-1:0] : '0;
        m_st = (m_st & ~ackm) | cap | swm;
        if (we && a == 3'd2) m_en = d[N-1:0];
        if (we && a == 3'd4) m_en = m_en | d[N-1:0];
        if (we && a == 3'd5) m_en = m_en & ~d[N-1:0];
        if (we && a == 3'd7) m_mer = d[1:0];
        m_prev = irq;
    endtask

    // One bus cycle: drive at the falling edge, check at the next falling edge.
    task automatic step(input logic [2:0] a, input logic we, input logic [31:0] d,
                        input logic [N-1:0] irq, input string tag);
        logic [31:0] exp;
        string rq;
        bus_addr = a; bus_we = we; bus_wdata = d; irq_in = irq;
        exp = m_read(a);
        m_update(a, we, d, irq);
        @(posedge clk);
        @(negedge clk);
        rq = (tag.len() == 0) ? req_of(a) : tag;
        chk(rq, bus_rdata, exp);
        chk((tag.len() == 0) ? "R9" : tag, 32'(cpu_irq),
            32'((&m_mer) & (|(m_st & m_en))));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [N-1:0] irq;
        m_st = '0; m_en = '0; m_prev = '0; m_mer = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", bus_rdata, 32'h0);
        chk("R1", 32'(cpu_irq), 32'h0);
        step(3'd0, 0, 0, '0, "R1");
        step(3'd2, 0, 0, '0, "R1");
        step(3'd7, 0, 0, '0, "R1");
        // R5 vector empty
        step(3'd6, 0, 0, '0, "R5");
        step(3'd6, 0, 0, '0, "R5");
        // R4 master readback, upper bits dropped
        step(3'd7, 1, 32'hFFFF_FFFE, '0, "R4");
        step(3'd7, 0, 0, '0, "R4");
        step(3'd7, 0, 0, '0, "R4");
        // R2 load / set / clear
        step(3'd2, 1, 32'h0000_00FF, '0, "R2");
        step(3'd4, 1, 32'h0000_0300, '0, "R2");
        step(3'd5, 1, 32'h0000_0011, '0, "R2");
        step(3'd2, 0, 0, '0, "R2");
        step(3'd2, 0, 0, '0, "R2");
        // R11 unused high bits zero, write-only index reads zero
        step(3'd4, 1, 32'hFFFF_FFFF, '0, "R11");
        step(3'd2, 0, 0, '0, "R11");
        step(3'd4, 0, 0, '0, "R11");
        // R6 edge line 1: rise, stay high, ack, remains clear
        irq = 20'h00002;
        step(3'd0, 0, 0, irq, "R6");
        step(3'd0, 0, 0, irq, "R6");
        step(3'd3, 1, 32'h2, irq, "R6");
        step(3'd0, 0, 0, irq, "R6");
        step(3'd0, 0, 0, '0, "R6");
        // R7 level line 4 re-latches while high
        irq = 20'h00010;
        step(3'd0, 0, 0, irq, "R7");
        step(3'd3, 1, 32'h10, irq, "R7");
        step(3'd0, 0, 0, irq, "R7");
        step(3'd3, 1, 32'h10, '0, "R7");
        step(3'd0, 0, 0, '0, "R7");
        step(3'd0, 0, 0, '0, "R7");
        // R12 line 16 is level (mask bit 0), line 19 level despite upper mask bits
        irq = 20'h90000;
        step(3'd0, 0, 0, irq, "R12");
        step(3'd3, 1, 32'h90000, irq, "R12");
        step(3'd0, 0, 0, '0, "R12");
        step(3'd3, 1, 32'hFFFF_FFFF, '0, "R3");
        step(3'd0, 0, 0, '0, "R3");
        // R10 status write ignored with hardware enable set, taken when clear
        step(3'd7, 1, 32'h3, '0, "R10");
        step(3'd0, 1, 32'h0000_1020, '0, "R10");
        step(3'd0, 0, 0, '0, "R10");
        step(3'd7, 1, 32'h1, '0, "R10");
        step(3'd0, 1, 32'h0000_1020, '0, "R10");
        step(3'd0, 0, 0, '0, "R10");
        // R5 / R8 / R9 lowest pending
        step(3'd7, 1, 32'h3, '0, "R9");
        step(3'd6, 0, 0, '0, "R5");
        step(3'd1, 0, 0, '0, "R8");
        step(3'd3, 1, 32'hFFFF_FFFF, '0, "R3");
        step(3'd0, 0, 0, '0, "R3");
        step(3'd6, 0, 0, '0, "R5");
        // Random traffic
        irq = '0;
        for (int k = 0; k < 4000; k++) begin
            logic [2:0]  a;
            logic        we;
            logic [31:0] d;
            a  = 3'($urandom);
            we = ($urandom % 3) == 0;
            d  = ($urandom % 4 == 0) ? (32'h1 << ($urandom % N)) : $urandom;
            if (a == 3'd3 && ($urandom % 8 == 0)) d = 32'hFFFF_FFFF;
            irq = irq ^ N'($urandom & $urandom & $urandom);
            step(a, we, d, irq, "");
        end
        finish_run();
    end

endmodule